// File: doc/BRIEF.md
# Directory Home Node Coherence Controller

This block is the single ordering point for a fixed set of cache lines. It keeps a small directory with one entry per line. Each entry holds a sharer bitmap with one bit per core and an owned flag. The owned flag marks that the one recorded sharer holds the line exclusively. Up to `NUM_CORES` cores present read or write requests, each on its own valid/ready pair. When several requests are pending, the block accepts exactly one. The lowest core index wins. All other requests are held until the accepted one has been granted.

Every accepted request spends one cycle on a directory lookup.

- **Reads:** a read of a line that no other core owns is granted with no probe, and the reader is added to the bitmap. If another core owns the line, a downgrade probe goes to that owner alone.
- **Writes:** a write sends invalidation probes only to the recorded sharers other than the writer. The block then waits until each probed core has acknowledged. Only then is the write granted, and the writer becomes the sole owner.

Data movement, cache arrays and the network are outside this block.

Top module: `dir_home`

## Requirements
- R1: After reset, `grant_valid` and `probe_valid` are 0, no `req_ready` bit is set while no request is valid, and every line has an empty sharer set.
- R2: When several `req_valid` bits are set in the same cycle, at most one `req_ready` bit is 1, and it belongs to the lowest-indexed requesting core.
- R3: Every accepted request spends one lookup cycle. `grant_valid` is never 1 in the cycle right after an acceptance.
- R4: A read of a line with no owner other than the reader is granted two cycles after the accepting edge, with no probe. The reader is added to the sharer bitmap.
- R5: A write to a line that has other sharers drives `probe_valid` for exactly one cycle. In that cycle `probe_mask` equals the sharer bitmap minus the writer's bit, and `probe_inval` is 1.
- R6: A probed write is granted only after every core in `probe_mask` has pulsed its `ack_valid` bit. The grant appears in the cycle after the last such acknowledgement.
- R7: After a granted write, the writer is the sole recorded sharer and owns the line. A later read by another core then probes only the writer, with `probe_inval` equal to 0 (downgrade), and afterwards both cores are sharers.
- R8: A write to a line that has no sharer other than the writer is granted without a probe, in the cycle after the lookup cycle.
- R9: From acceptance until the grant cycle, all `req_ready` bits are 0.
- R10: `ack_valid` pulses from cores that are not in the current `probe_mask` have no effect. They do not bring the grant forward.
- R11: `probe_mask` never includes the bit of the core whose request is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | Per-core request valid |
| req_write | input | NUM_CORES | Per-core request kind: 1 write, 0 read |
| req_line | input | NUM_CORES*LINE_W | Per-core line index; core i uses bits [i*LINE_W +: LINE_W] |
| req_ready | output | NUM_CORES | Per-core acceptance; a request is taken on a clock edge where valid and ready are both 1 |
| probe_valid | output | 1 | Probe broadcast cycle |
| probe_mask | output | NUM_CORES | Cores addressed by the probe |
| probe_inval | output | 1 | 1 invalidate, 0 downgrade |
| ack_valid | input | NUM_CORES | Per-core probe acknowledgement pulse |
| grant_valid | output | 1 | Grant cycle |
| grant_core | output | CORE_W | Core receiving the grant |
| grant_write | output | 1 | Kind of the granted request |
| grant_line | output | LINE_W | Line of the granted request |

## Verification
The in-RTL assertions watch the ordering rules on every cycle:
- at most one ready bit is set, and none while a request is in progress;
- no grant appears in the cycle after an acceptance;
- every probe is a nonempty single-cycle pulse that excludes the requester;
- no grant appears while a probed core is still unacknowledged.

Only the directed scenarios show the content-dependent behaviour:
- that the probe mask matches the sharers recorded by earlier reads and writes;
- that ownership passes to the writer and later yields a downgrade probe;
- that acknowledgements from unprobed cores are ignored;
- the exact grant cycle for each path.

// File: rtl/dir_pkg.sv
package dir_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_PROBE  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_GRANT  = 3'd4
    } home_state_t;
endpackage

// File: rtl/dir_arbiter.sv
module dir_arbiter #(
    parameter int NUM_CORES = 16,
    localparam int CORE_W = $clog2(NUM_CORES)
) (
    input  logic [NUM_CORES-1:0] req,
    output logic [NUM_CORES-1:0] gnt,
    output logic [CORE_W-1:0]    idx,
    output logic                 any
);
    // Fixed priority: lowest index wins.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                idx    = CORE_W'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dir_table.sv
module dir_table #(
    parameter int NUM_CORES = 16,
    parameter int NUM_LINES = 8,
    localparam int LINE_W  = $clog2(NUM_LINES),
    localparam int ENTRY_W = NUM_CORES + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINE_W-1:0]  rd_line,
    output logic [ENTRY_W-1:0] rd_entry,
    input  logic               wr_en,
    input  logic [LINE_W-1:0]  wr_line,
    input  logic [ENTRY_W-1:0] wr_entry
);
    // Entry layout: [NUM_CORES] owned flag, [NUM_CORES-1:0] sharer bitmap.
    logic [ENTRY_W-1:0] mem_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_line] <= wr_entry;
        end
    end

    assign rd_entry = mem_q[rd_line];
endmodule

// File: rtl/dir_home.sv
module dir_home
    import dir_pkg::*;
#(
    parameter int NUM_CORES = 16,
    parameter int NUM_LINES = 8,
    localparam int CORE_W  = $clog2(NUM_CORES),
    localparam int LINE_W  = $clog2(NUM_LINES),
    localparam int ENTRY_W = NUM_CORES + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES-1:0]        req_valid,
    input  logic [NUM_CORES-1:0]        req_write,
    input  logic [NUM_CORES*LINE_W-1:0] req_line,
    output logic [NUM_CORES-1:0]        req_ready,
    output logic                        probe_valid,
    output logic [NUM_CORES-1:0]        probe_mask,
    output logic                        probe_inval,
    input  logic [NUM_CORES-1:0]        ack_valid,
    output logic                        grant_valid,
    output logic [CORE_W-1:0]           grant_core,
    output logic                        grant_write,
    output logic [LINE_W-1:0]           grant_line
);
    typedef struct packed {
        home_state_t            st;
        logic [CORE_W-1:0]      core;
        logic                   wr;
        logic [LINE_W-1:0]      line;
        logic [NUM_CORES-1:0]   pend;
        logic [NUM_CORES-1:0]   new_sh;
        logic                   new_own;
    } ctl_t;

    ctl_t r_q, r_d;

    logic [NUM_CORES-1:0] arb_gnt;
    logic [CORE_W-1:0]    arb_idx;
    logic                 arb_any;
    logic [ENTRY_W-1:0]   ent_rd;
    logic [ENTRY_W-1:0]   ent_wr;
    logic                 tbl_we;
    logic [NUM_CORES-1:0] req_bit;
    logic [NUM_CORES-1:0] others;
    logic                 accepted;

    dir_arbiter #(.NUM_CORES(NUM_CORES)) u_arb (
        .req (req_valid),
        .gnt (arb_gnt),
        .idx (arb_idx),
        .any (arb_any)
    );

    dir_table #(.NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_line  (r_q.line),
        .rd_entry (ent_rd),
        .wr_en    (tbl_we),
        .wr_line  (r_q.line),
        .wr_entry (ent_wr)
    );

    assign req_bit  = NUM_CORES'(1) << r_q.core;
    assign others   = ent_rd[NUM_CORES-1:0] & ~req_bit;
    assign req_ready = (r_q.st == ST_IDLE) ? arb_gnt : '0;
    assign accepted  = |(req_ready & req_valid);

    assign probe_valid = (r_q.st == ST_PROBE);
    assign probe_mask  = probe_valid ? r_q.pend : '0;
    assign probe_inval = probe_valid & r_q.wr;
    assign grant_valid = (r_q.st == ST_GRANT);
    assign grant_core  = r_q.core;
    assign grant_write = r_q.wr;
    assign grant_line  = r_q.line;
    assign tbl_we      = grant_valid;
    assign ent_wr      = {r_q.new_own, r_q.new_sh};

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (arb_any) begin
                    r_d.st   = ST_LOOKUP;
                    r_d.core = arb_idx;
                    r_d.wr   = req_write[arb_idx];
                    r_d.line = req_line[arb_idx*LINE_W +: LINE_W];
                end
            end
            ST_LOOKUP: begin
                if (r_q.wr) begin
                    r_d.pend    = others;
                    r_d.new_sh  = req_bit;
                    r_d.new_own = 1'b1;
                end else if (ent_rd[NUM_CORES] && (others != '0)) begin
                    r_d.pend    = others;
                    r_d.new_sh  = ent_rd[NUM_CORES-1:0] | req_bit;
                    r_d.new_own = 1'b0;
                end else begin
                    r_d.pend    = '0;
                    r_d.new_sh  = ent_rd[NUM_CORES-1:0] | req_bit;
                    r_d.new_own = ent_rd[NUM_CORES];
                end
                r_d.st = (r_d.pend == '0) ? ST_GRANT : ST_PROBE;
            end
            ST_PROBE, ST_WAIT: begin
                r_d.pend = r_q.pend & ~ack_valid;
                r_d.st   = (r_d.pend == '0) ? ST_GRANT : ST_WAIT;
            end
            ST_GRANT: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready)); // R2
    AST_LOOKUP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> !grant_valid); // R3
    AST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> (req_ready == '0)); // R9
    AST_PROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |=> !probe_valid); // R5
    AST_PROBE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> (probe_mask != '0)); // R5
    AST_PROBE_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> !probe_mask[grant_core]); // R11
    AST_GRANT_AFTER_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (r_q.pend == '0)); // R6
endmodule

// File: tb/tb_dir_home.sv
`timescale 1ns/1ps
module tb_dir_home;
    localparam int N  = 16;
    localparam int NL = 8;
    localparam int LW = $clog2(NL);
    localparam int CW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N-1:0]    req_write = '0;
    logic [N*LW-1:0] req_line = '0;
    logic [N-1:0]    req_ready;
    logic            probe_valid;
    logic [N-1:0]    probe_mask;
    logic            probe_inval;
    logic [N-1:0]    ack_valid = '0;
    logic            grant_valid;
    logic [CW-1:0]   grant_core;
    logic            grant_write;
    logic [LW-1:0]   grant_line;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dir_home #(.NUM_CORES(N), .NUM_LINES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_line(req_line), .req_ready(req_ready), .probe_valid(probe_valid),
        .probe_mask(probe_mask), .probe_inval(probe_inval), .ack_valid(ack_valid),
        .grant_valid(grant_valid), .grant_core(grant_core), .grant_write(grant_write),
        .grant_line(grant_line)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one request at a negedge; return at the negedge after acceptance (lookup cycle).
    task automatic issue(input int c, input bit wr, input int line);
        @(negedge clk);
        req_valid[c] = 1'b1;
        req_write[c] = wr;
        req_line[c*LW +: LW] = LW'(line);
        #1;
        while (!req_ready[c]) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid[c] = 1'b0;
        chk(grant_valid == 1'b0, "R3 no grant in lookup cycle", grant_valid, 0);
        chk(req_ready == '0, "R9 ready held low", req_ready, 0);
    endtask

    task automatic expect_grant(input string tag, input int c, input bit wr, input int line);
        chk(grant_valid == 1'b1, tag, grant_valid, 1);
        chk(grant_core == CW'(c), tag, grant_core, c);
        chk(grant_write == wr, tag, grant_write, wr);
        chk(grant_line == LW'(line), tag, grant_line, line);
    endtask

    task automatic pulse_ack(input int c);
        ack_valid[c] = 1'b1;
        @(negedge clk);
        ack_valid[c] = 1'b0;
    endtask

    task automatic t_reset();
        chk(grant_valid == 0, "R1 grant idle", grant_valid, 0);
        chk(probe_valid == 0, "R1 probe idle", probe_valid, 0);
        chk(req_ready == '0, "R1 ready idle", req_ready, 0);
    endtask

    task automatic t_reads_no_probe();
        issue(3, 1'b0, 1);
        @(negedge clk);
        chk(probe_valid == 0, "R4 no probe on read", probe_valid, 0);
        expect_grant("R4 read grant", 3, 1'b0, 1);
        issue(5, 1'b0, 1);
        @(negedge clk);
        expect_grant("R4 second read grant", 5, 1'b0, 1);
    endtask

    task automatic t_write_probes();
        issue(9, 1'b1, 1);
        @(negedge clk);
        chk(probe_valid == 1, "R5 probe issued", probe_valid, 1);
        chk(probe_mask == N'((1 << 3) | (1 << 5)), "R5 probe mask sharers", probe_mask, (1 << 3) | (1 << 5));
        chk(probe_inval == 1, "R5 invalidate flag", probe_inval, 1);
        pulse_ack(7);
        chk(probe_valid == 0, "R5 probe one cycle", probe_valid, 0);
        chk(grant_valid == 0, "R10 stray ack ignored", grant_valid, 0);
        pulse_ack(3);
        @(negedge clk);
        chk(grant_valid == 0, "R6 partial acks no grant", grant_valid, 0);
        pulse_ack(5);
        expect_grant("R6 grant after last ack", 9, 1'b1, 1);
    endtask

    task automatic t_owner_downgrade();
        issue(3, 1'b0, 1);
        @(negedge clk);
        chk(probe_valid == 1, "R7 probe owner", probe_valid, 1);
        chk(probe_mask == N'(1 << 9), "R7 only owner probed", probe_mask, 1 << 9);
        chk(probe_inval == 0, "R7 downgrade flag", probe_inval, 0);
        pulse_ack(9);
        expect_grant("R7 read grant after downgrade", 3, 1'b0, 1);
        issue(3, 1'b1, 1);
        @(negedge clk);
        chk(probe_valid == 1, "R11 probe on upgrade", probe_valid, 1);
        chk(probe_mask == N'(1 << 9), "R11 requester excluded", probe_mask, 1 << 9);
        pulse_ack(9);
        expect_grant("R11 upgrade grant", 3, 1'b1, 1);
    endtask

    task automatic t_write_empty();
        issue(2, 1'b1, 4);
        @(negedge clk);
        chk(probe_valid == 0, "R8 no probe", probe_valid, 0);
        expect_grant("R8 immediate write grant", 2, 1'b1, 4);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        req_valid[6] = 1'b1; req_write[6] = 1'b0; req_line[6*LW +: LW] = LW'(5);
        req_valid[1] = 1'b1; req_write[1] = 1'b0; req_line[1*LW +: LW] = LW'(5);
        #1;
        chk(req_ready == N'(1 << 1), "R2 lowest index ready", req_ready, 1 << 1);
        @(negedge clk);
        req_valid[1] = 1'b0;
        chk(req_ready[6] == 0, "R9 second held", req_ready[6], 0);
        @(negedge clk);
        expect_grant("R2 first grant core1", 1, 1'b0, 5);
        chk(req_ready[6] == 0, "R9 held in grant", req_ready[6], 0);
        @(negedge clk);
        chk(req_ready[6] == 1, "R2 second accepted", req_ready[6], 1);
        @(negedge clk);
        req_valid[6] = 1'b0;
        @(negedge clk);
        expect_grant("R2 second grant core6", 6, 1'b0, 5);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_reads_no_probe();
                t_write_probes();
                t_owner_downgrade();
                t_write_empty();
                t_same_cycle();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule